// File: doc/BRIEF.md
# Cache Line Fill and Victim Copy-Back Controller

This block services a data cache read miss. When a miss is accepted it starts the external read of the new line in that same cycle and, if the victim line chosen by the replacement logic is dirty, it copies the whole victim into a single-entry copy-back buffer at the same clock edge. The new line comes back as four 64-bit beats, which may arrive with gaps. The first beat goes straight through to the requester in the cycle it arrives, so execution can continue while the rest of the line is still being transferred.

Once all four beats are in, the assembled line is presented for installation into the selected way, together with the line's new state and a one-cycle done pulse. Meanwhile, the copy-back buffer drains the old victim to memory beat by beat, independently of the fill. A clean victim bypasses the buffer entirely. The tag lookup, the way choice and the coherence result are made outside the block and arrive with the miss request.

Top module: `lfill_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1 and `rd_start`, `fill_ready`, `fwd_valid`, `inst_valid` and `wb_valid` are 0.
- R2: A miss is accepted in a cycle where `miss_valid` and `miss_ready` are both 1. In that same cycle `rd_start` is 1 and `rd_addr` equals `miss_addr`. In every other cycle `rd_start` is 0.
- R3: `fill_ready` is 1 exactly while an accepted miss still awaits beats. A beat is taken only in a cycle with `fill_valid` and `fill_ready` both 1. Idle cycles between beats are allowed.
- R4: In the cycle the first beat of a fill is taken, `fwd_valid` is 1 and `fwd_data` equals `fill_data`. `fwd_valid` is 0 for the other three beats and in all other cycles.
- R5: In the cycle after the fourth beat is taken, `inst_valid` is 1 for one cycle only. At that point `inst_data` holds beat k in bits [64k+63:64k], and `inst_addr`, `inst_way` and `inst_state` equal the `miss_addr`, `miss_way` and `miss_state` that were accepted. The `miss_state` encoding (0 invalid, 1 shared, 2 exclusive, 3 modified) is passed through unchanged.
- R6: While a fill is in progress, `miss_ready` is 0.
- R7: When a miss is accepted with `victim_dirty` at 1, `wb_valid` is 1 from the next cycle, and `wb_addr` equals the accepted `victim_addr`. The buffer presents `wb_beat` values 0, 1, 2, 3 in order, moving to the next beat on each cycle with `wb_valid` and `wb_ready` both 1. `wb_valid` falls after beat 3 is taken.
- R8: A miss accepted with `victim_dirty` at 0 does not load the copy-back buffer: if the buffer was empty, `wb_valid` stays 0.
- R9: A miss with `victim_dirty` at 1 is held off (`miss_ready` 0) while the buffer still holds an undrained victim. A miss with a clean victim is not held off by the buffer.
- R10: `wb_data` for beat k is bits [64k+63:64k] of the `victim_data` sampled at acceptance. Later changes on the victim inputs do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Read miss request |
| miss_ready | output | 1 | Miss can be accepted this cycle |
| miss_addr | input | ADDR_W | Line address of the missing line |
| miss_way | input | log2(WAYS) | Way selected for the new line |
| miss_state | input | 2 | State to give the installed line |
| victim_dirty | input | 1 | Line being replaced is modified |
| victim_addr | input | ADDR_W | Line address of the victim |
| victim_data | input | 4*BEAT_W | Victim contents, beat k at bits [64k+63:64k] |
| rd_start | output | 1 | Start of the external fill read |
| rd_addr | output | ADDR_W | Address of the fill read |
| fill_valid | input | 1 | Fill beat present |
| fill_ready | output | 1 | Fill beat can be taken |
| fill_data | input | BEAT_W | Fill beat data |
| fwd_valid | output | 1 | Critical beat forwarded to requester |
| fwd_data | output | BEAT_W | Forwarded beat |
| inst_valid | output | 1 | Done pulse: install the line now |
| inst_addr | output | ADDR_W | Address of the installed line |
| inst_way | output | log2(WAYS) | Way to write |
| inst_state | output | 2 | New state of the line |
| inst_data | output | 4*BEAT_W | Assembled line |
| wb_valid | output | 1 | Write-back beat present |
| wb_ready | input | 1 | Memory takes the write-back beat |
| wb_addr | output | ADDR_W | Victim line address |
| wb_data | output | BEAT_W | Write-back beat data |
| wb_beat | output | 2 | Index of the write-back beat |

## Verification
The hardest case to reach is a dirty miss that arrives while the previous victim is still sitting in the copy-back buffer. Reaching it needs a whole fill to complete while memory refuses write-back beats. The stimulus creates this with a phase that holds `wb_ready` low and offers a dirty miss on every cycle. It then switches to clean victims while the buffer is still full, to show that those misses are not held off, and only then releases the drain. The remaining phases use random gaps on both fill and drain, against a queue-based reference model.

// File: rtl/lfill_pkg.sv
package lfill_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } lstate_e;
endpackage

// File: rtl/lfill_seq.sv
module lfill_seq
    import lfill_pkg::*;
#(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    parameter int ADDR_W = 32,
    parameter int WAY_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       start_addr,
    input  logic [WAY_W-1:0]        start_way,
    input  lstate_e                 start_state,
    input  logic                    fill_valid,
    input  logic [BEAT_W-1:0]       fill_data,
    output logic                    busy,
    output logic                    fill_ready,
    output logic                    fwd_valid,
    output logic [BEAT_W-1:0]       fwd_data,
    output logic                    inst_valid,
    output logic [ADDR_W-1:0]       inst_addr,
    output logic [WAY_W-1:0]        inst_way,
    output lstate_e                 inst_state,
    output logic [BEATS*BEAT_W-1:0] inst_data
);
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    typedef struct packed {
        logic                          busy;
        logic                          done;
        logic [CNT_W-1:0]              cnt;
        logic [BEATS-1:0][BEAT_W-1:0]  line;
        logic [ADDR_W-1:0]             addr;
        logic [WAY_W-1:0]              way;
        lstate_e                       st;
    } seq_t;

    seq_t s_d, s_q;
    logic take;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        take     = s_q.busy && fill_valid;
        if (take) begin
            s_d.line[s_q.cnt] = fill_data;
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.addr = start_addr;
            s_d.way  = start_way;
            s_d.st   = start_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = s_q.busy;
    assign fill_ready = s_q.busy;
    assign fwd_valid  = take && (s_q.cnt == '0);
    assign fwd_data   = fill_data;
    assign inst_valid = s_q.done;
    assign inst_addr  = s_q.addr;
    assign inst_way   = s_q.way;
    assign inst_state = s_q.st;
    assign inst_data  = s_q.line;
endmodule

// File: rtl/lfill_cbbuf.sv
module lfill_cbbuf #(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       load_addr,
    input  logic [BEATS*BEAT_W-1:0] load_data,
    input  logic                    wb_ready,
    output logic                    full,
    output logic                    wb_valid,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [BEAT_W-1:0]       wb_data,
    output logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] wb_beat
);
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    typedef struct packed {
        logic                          vld;
        logic [CNT_W-1:0]              cnt;
        logic [ADDR_W-1:0]             addr;
        logic [BEATS-1:0][BEAT_W-1:0]  data;
    } cb_t;

    cb_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (c_q.vld && wb_ready) begin
            if (c_q.cnt == LAST) begin
                c_d.vld = 1'b0;
                c_d.cnt = '0;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
        if (load) begin
            c_d.vld  = 1'b1;
            c_d.cnt  = '0;
            c_d.addr = load_addr;
            c_d.data = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign full     = c_q.vld;
    assign wb_valid = c_q.vld;
    assign wb_addr  = c_q.addr;
    assign wb_data  = c_q.data[c_q.cnt];
    assign wb_beat  = c_q.cnt;
endmodule

// File: rtl/lfill_ctrl.sv
module lfill_ctrl
    import lfill_pkg::*;
#(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    output logic                    miss_ready,
    input  logic [ADDR_W-1:0]       miss_addr,
    input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] miss_way,
    input  logic [1:0]              miss_state,
    input  logic                    victim_dirty,
    input  logic [ADDR_W-1:0]       victim_addr,
    input  logic [BEATS*BEAT_W-1:0] victim_data,
    output logic                    rd_start,
    output logic [ADDR_W-1:0]       rd_addr,
    input  logic                    fill_valid,
    output logic                    fill_ready,
    input  logic [BEAT_W-1:0]       fill_data,
    output logic                    fwd_valid,
    output logic [BEAT_W-1:0]       fwd_data,
    output logic                    inst_valid,
    output logic [ADDR_W-1:0]       inst_addr,
    output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] inst_way,
    output logic [1:0]              inst_state,
    output logic [BEATS*BEAT_W-1:0] inst_data,
    output logic                    wb_valid,
    input  logic                    wb_ready,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [BEAT_W-1:0]       wb_data,
    output logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] wb_beat
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic    seq_busy;
    logic    cb_full;
    logic    accept;
    lstate_e st_out;

    // Dirty victims need the buffer; clean ones only need the sequencer.
    assign miss_ready = !seq_busy && !(victim_dirty && cb_full);
    assign accept     = miss_valid && miss_ready;
    assign rd_start   = accept;
    assign rd_addr    = miss_addr;
    assign inst_state = st_out;

    lfill_seq #(
        .BEAT_W(BEAT_W), .BEATS(BEATS), .ADDR_W(ADDR_W), .WAY_W(WAY_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_addr  (miss_addr),
        .start_way   (miss_way),
        .start_state (lstate_e'(miss_state)),
        .fill_valid  (fill_valid),
        .fill_data   (fill_data),
        .busy        (seq_busy),
        .fill_ready  (fill_ready),
        .fwd_valid   (fwd_valid),
        .fwd_data    (fwd_data),
        .inst_valid  (inst_valid),
        .inst_addr   (inst_addr),
        .inst_way    (inst_way),
        .inst_state  (st_out),
        .inst_data   (inst_data)
    );

    lfill_cbbuf #(
        .BEAT_W(BEAT_W), .BEATS(BEATS), .ADDR_W(ADDR_W)
    ) u_cb (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && victim_dirty),
        .load_addr (victim_addr),
        .load_data (victim_data),
        .wb_ready  (wb_ready),
        .full      (cb_full),
        .wb_valid  (wb_valid),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data),
        .wb_beat   (wb_beat)
    );
endmodule

// File: rtl/lfill_chk.sv
module lfill_chk #(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              victim_dirty,
    input logic              fill_valid,
    input logic              fill_ready,
    input logic              fwd_valid,
    input logic              inst_valid,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [BEAT_W-1:0] wb_data,
    input logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] wb_beat
);
    a_r6_no_accept_while_filling: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ready |-> !miss_ready);

    a_r4_fwd_on_taken_beat: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fill_valid && fill_ready));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        inst_valid |=> !inst_valid);

    a_r5_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        inst_valid |-> $past(fill_valid && fill_ready));

    a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_beat) && $stable(wb_data)));

    a_r8_clean_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && !victim_dirty && !wb_valid) |=> !wb_valid);

    a_r9_dirty_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && victim_dirty) |-> !miss_ready);
endmodule

bind lfill_ctrl lfill_chk #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_chk (.*);

// File: tb/lfill_ctrl_bench.sv
module lfill_ctrl_bench;
    localparam int BW = 64;
    localparam int NB = 4;
    localparam int AW = 32;
    localparam int LW = BW * NB;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          miss_valid, miss_ready;
    logic [AW-1:0] miss_addr;
    logic [1:0]    miss_way, miss_state;
    logic          victim_dirty;
    logic [AW-1:0] victim_addr;
    logic [LW-1:0] victim_data;
    logic          rd_start;
    logic [AW-1:0] rd_addr;
    logic          fill_valid, fill_ready;
    logic [BW-1:0] fill_data;
    logic          fwd_valid;
    logic [BW-1:0] fwd_data;
    logic          inst_valid;
    logic [AW-1:0] inst_addr;
    logic [1:0]    inst_way, inst_state;
    logic [LW-1:0] inst_data;
    logic          wb_valid, wb_ready;
    logic [AW-1:0] wb_addr;
    logic [BW-1:0] wb_data;
    logic [1:0]    wb_beat;

    always #5 clk = ~clk;

    lfill_ctrl u_lfill_ctrl (.*);

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // reference model state
    bit            m_busy = 0;
    int            m_cnt = 0;
    logic [LW-1:0] m_acc;
    logic [AW-1:0] m_addr;
    logic [1:0]    m_way, m_state;
    bit            m_done = 0;
    logic [BW-1:0] m_cbq[$];
    logic [AW-1:0] m_cb_addr;

    int p_miss, p_dirty, p_fill, p_wb;

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit pct(input int p);
        return ($urandom % 100) < p;
    endfunction

    function automatic logic [BW-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic step();
        bit e_ready, e_acc, e_take;
        @(negedge clk);
        miss_valid   = pct(p_miss);
        miss_addr    = $urandom;
        miss_way     = 2'($urandom);
        miss_state   = 2'($urandom);
        victim_dirty = pct(p_dirty);
        victim_addr  = $urandom;
        for (int k = 0; k < NB; k++) victim_data[k*BW +: BW] = rnd64();
        fill_valid   = pct(p_fill);
        fill_data    = rnd64();
        wb_ready     = pct(p_wb);
        #1;
        e_ready = !m_busy && !(victim_dirty && m_cbq.size() > 0);
        e_acc   = miss_valid && e_ready;
        e_take  = m_busy && fill_valid;
        if (m_busy)
            chk(miss_ready === e_ready, "R6 miss_ready", LW'(miss_ready), LW'(e_ready));
        else if (victim_dirty && m_cbq.size() > 0)
            chk(miss_ready === e_ready, "R9 miss_ready", LW'(miss_ready), LW'(e_ready));
        else
            chk(miss_ready === e_ready, "R9 clean/idle miss_ready", LW'(miss_ready), LW'(e_ready));
        chk(rd_start === e_acc, "R2 rd_start", LW'(rd_start), LW'(e_acc));
        if (e_acc) chk(rd_addr === miss_addr, "R2 rd_addr", LW'(rd_addr), LW'(miss_addr));
        chk(fill_ready === m_busy, "R3 fill_ready", LW'(fill_ready), LW'(m_busy));
        chk(fwd_valid === (e_take && m_cnt == 0), "R4 fwd_valid", LW'(fwd_valid),
            LW'(e_take && m_cnt == 0));
        if (e_take && m_cnt == 0)
            chk(fwd_data === fill_data, "R4 fwd_data", LW'(fwd_data), LW'(fill_data));
        chk(inst_valid === m_done, "R5 inst_valid", LW'(inst_valid), LW'(m_done));
        if (m_done) begin
            chk(inst_data === m_acc, "R5 inst_data", inst_data, m_acc);
            chk(inst_addr === m_addr, "R5 inst_addr", LW'(inst_addr), LW'(m_addr));
            chk(inst_way === m_way, "R5 inst_way", LW'(inst_way), LW'(m_way));
            chk(inst_state === m_state, "R5 inst_state", LW'(inst_state), LW'(m_state));
        end
        if (m_cbq.size() == 0) begin
            chk(wb_valid === 1'b0, "R8 wb_valid idle", LW'(wb_valid), 0);
        end else begin
            chk(wb_valid === 1'b1, "R7 wb_valid", LW'(wb_valid), 1);
            chk(wb_addr === m_cb_addr, "R7 wb_addr", LW'(wb_addr), LW'(m_cb_addr));
            chk(wb_beat === 2'(NB - m_cbq.size()), "R7 wb_beat", LW'(wb_beat),
                LW'(NB - m_cbq.size()));
            chk(wb_data === m_cbq[0], "R10 wb_data", LW'(wb_data), LW'(m_cbq[0]));
        end
        // advance model to the state after this edge
        m_done = 0;
        if (m_cbq.size() > 0 && wb_ready) void'(m_cbq.pop_front());
        if (e_take) begin
            m_acc[m_cnt*BW +: BW] = fill_data;
            m_cnt++;
            if (m_cnt == NB) begin
                m_busy = 0;
                m_done = 1;
                m_cnt  = 0;
            end
        end
        if (e_acc) begin
            m_busy  = 1;
            m_cnt   = 0;
            m_addr  = miss_addr;
            m_way   = miss_way;
            m_state = miss_state;
            if (victim_dirty) begin
                m_cb_addr = victim_addr;
                for (int k = 0; k < NB; k++) m_cbq.push_back(victim_data[k*BW +: BW]);
            end
        end
    endtask

    task automatic run(input int cycles, input int pm, input int pd, input int pf,
                       input int pw);
        p_miss = pm; p_dirty = pd; p_fill = pf; p_wb = pw;
        for (int i = 0; i < cycles; i++) step();
    endtask

    initial begin
        rst_n = 1'b0;
        miss_valid = 0; miss_addr = '0; miss_way = '0; miss_state = '0;
        victim_dirty = 0; victim_addr = '0; victim_data = '0;
        fill_valid = 0; fill_data = '0; wb_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(miss_ready === 1'b1, "R1 miss_ready", LW'(miss_ready), 1);
        chk(rd_start === 1'b0, "R1 rd_start", LW'(rd_start), 0);
        chk(fill_ready === 1'b0, "R1 fill_ready", LW'(fill_ready), 0);
        chk(fwd_valid === 1'b0, "R1 fwd_valid", LW'(fwd_valid), 0);
        chk(inst_valid === 1'b0, "R1 inst_valid", LW'(inst_valid), 0);
        chk(wb_valid === 1'b0, "R1 wb_valid", LW'(wb_valid), 0);
        rst_n = 1'b1;
        // mixed traffic
        run(300, 50, 50, 50, 50);
        // drain blocked: dirty misses collide with a full buffer (R9)
        run(60, 100, 100, 100, 0);
        // clean victims while buffer still full (R8, R9)
        run(30, 100, 0, 100, 0);
        // release the drain
        run(20, 0, 0, 100, 100);
        // back-to-back fills and drains
        run(200, 100, 100, 100, 100);
        // sparse fill beats with gaps (R3)
        run(300, 60, 70, 20, 40);
        // clean-only traffic (R8)
        run(100, 80, 0, 60, 50);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule